// File: doc/BRIEF.md
# Synthesizer configuration serial writer

This block keeps the full set of configuration fields for an external RF synthesizer and transmitter. It packs them into four 32-bit control words and sends those words over a three-wire link: a load-enable strobe, a serial clock and a data line. Software-side logic presents the field values on dedicated inputs and captures them with a write strobe. It then asks for one of two transfers. The first is a full update that sends all four words. The second is a fast retune that resends only word 0, with a tone offset added to its correction field, so that a 4-level FSK symbol can be keyed with a single word.

Every gap on the link is a multiple of a programmable wait count W, which resets to 5. Each transfer opens with a load-enable pulse and a short setup gap. The bits follow, each with its own low clock phase. The transfer closes with a latch in which the clock is released before load-enable. A tone request that arrives while a full update is running is held in a one-entry slot. It goes out directly after word 3 has been latched.

Top module: `synth_cfg_writer`

## Requirements
- R1: Each word is 32 bits, sent most significant bit first. Bits [1:0] hold the word's address (0 to 3). A full update sends the words with addresses 0, 1, 2 and 3, in that order.
- R2: Word 0 fields: correction [12:2], R divider [16:13], crystal doubler bit 17, oscillator off bit 18, clock-out divider [22:19], VCO adjust [24:23], output divider [26:25]. All other bits are 0.
- R3: Word 1 fields: fractional N [13:2], integer N [21:14], prescaler select bit 22. Word 2 fields: modulation select [3:2], shaped on-off bit 4, power level [10:5], deviation [19:11], shaping control [22:20], index count [24:23]. All other bits are 0.
- R4: Word 3 fields: PLL enable bit 2, PA enable bit 3, clock-out enable bit 4, data invert bit 5, charge pump [7:6], bleed up bit 8, bleed down bit 9, VCO off bit 10, mux select [14:11], lock precision bit 15, VCO bias [19:16], PA bias [22:20], PLL test [27:23], modulator test [31:28].
- R5: A word starts with load-enable high for 2·W cycles while clock and data stay high. Then load-enable goes low, clock and data go low for W cycles, and the first bit's low phase follows. The clock is therefore low for 3·W cycles before its first rise.
- R6: For each bit, the clock is low for 2·W cycles with the bit on the data line, then rises. The data is valid at the rising edge. Between bits the clock is high for one cycle.
- R7: On the 32nd rising clock edge, load-enable rises with the clock. Both stay high for 2·W cycles. The clock then goes low for one cycle with load-enable still high, and then load-enable goes low.
- R8: A tone request sends word 0 only. Its correction field is (stored correction + tone offset) mod 2^11. The stored correction is not changed, so the next full update carries the original value.
- R9: An accepted request raises busy, and load-enable, in the next cycle. Busy stays high through all the words of the transfer and drops one cycle after load-enable falls at the end of the last word. While idle, clock = 1, data = 1 and load-enable = 0.
- R10: While busy, a full request is ignored. So is a tone request during a tone transfer, or when a tone is already queued. A configuration write is ignored as well. None of these adds a word or changes a field.
- R11: A tone request during a full update, or one that comes in the same idle cycle as a full request, is queued. It is sent as word 0 immediately after word 3 is latched, and busy stays high in between.
- R12: Reset returns the link to its idle levels and loads all fields as 0, except R divider = 1, VCO adjust = 3, PA bias = 7 and W = 5.
- R13: A wait count of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| corr | input | 11 | Frequency correction |
| rDiv | input | 4 | Reference divider |
| xtalDbl | input | 1 | Crystal doubler |
| oscOff | input | 1 | Oscillator disable |
| clkOutDiv | input | 4 | Clock-out divider |
| vcoAdj | input | 2 | VCO adjust |
| outDiv | input | 2 | Output divider |
| fracN | input | 12 | Fractional N |
| intN | input | 8 | Integer N |
| presc | input | 1 | Prescaler select |
| modSel | input | 2 | Modulation select |
| shapedOok | input | 1 | Shaped on-off keying |
| paLevel | input | 6 | Power level |
| deviation | input | 9 | Frequency deviation |
| shapeCtl | input | 3 | Shaping control |
| indexCnt | input | 2 | Index count |
| pllEn | input | 1 | PLL enable |
| paEn | input | 1 | PA enable |
| clkOutEn | input | 1 | Clock-out enable |
| dataInv | input | 1 | Data invert |
| cpCur | input | 2 | Charge pump current |
| bleedUp | input | 1 | Bleed up |
| bleedDn | input | 1 | Bleed down |
| vcoOff | input | 1 | VCO disable |
| muxSel | input | 4 | Mux-out select |
| ldPrec | input | 1 | Lock detect precision |
| vcoBias | input | 4 | VCO bias |
| paBias | input | 3 | PA bias |
| pllTest | input | 5 | PLL test mode |
| modTest | input | 4 | Modulator test mode |
| waitIn | input | WAIT_W | Wait count W |
| cfgWe | input | 1 | Capture all field inputs and W (idle only) |
| startFull | input | 1 | Request a full four-word update |
| startTone | input | 1 | Request a tone retune |
| toneOfs | input | TONE_W | Tone offset added to the correction |
| le | output | 1 | Load-enable |
| sclk | output | 1 | Serial clock |
| sdata | output | 1 | Serial data |
| busy | output | 1 | Transfer in progress |

## Verification
Two functions can fall in the same cycle: starting a full update and taking a tone request. The bench provokes this by raising both requests in one idle cycle. It also raises a tone request partway through a full update and then raises a second one while the first is still queued. The scoreboard expects the four full words, then exactly one tone word with the summed correction. It flags any missing, extra or reordered word, and any word whose timing breaks the framing rules.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

  localparam int WORD_W = 32;
  localparam int CORR_W = 11;

  typedef struct packed {
    logic [CORR_W-1:0] corr;
    logic [3:0]  rDiv;
    logic        xtalDbl;
    logic        oscOff;
    logic [3:0]  clkOutDiv;
    logic [1:0]  vcoAdj;
    logic [1:0]  outDiv;
    logic [11:0] fracN;
    logic [7:0]  intN;
    logic        presc;
    logic [1:0]  modSel;
    logic        shapedOok;
    logic [5:0]  paLevel;
    logic [8:0]  deviation;
    logic [2:0]  shapeCtl;
    logic [1:0]  indexCnt;
    logic        pllEn;
    logic        paEn;
    logic        clkOutEn;
    logic        dataInv;
    logic [1:0]  cpCur;
    logic        bleedUp;
    logic        bleedDn;
    logic        vcoOff;
    logic [3:0]  muxSel;
    logic        ldPrec;
    logic [3:0]  vcoBias;
    logic [2:0]  paBias;
    logic [4:0]  pllTest;
    logic [3:0]  modTest;
  } cfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;     // load a new word into the shifter
    logic [1:0] sel;      // word address for a full update
    logic       tone;     // load word 0 with tone-adjusted correction
    logic       shift;    // advance shifter by one bit
    logic       capTone;  // capture tone offset input
    logic       cfgTake;  // capture configuration inputs
  } strobe_t;

  function automatic cfg_t defaultCfg();
    cfg_t c;
    c = '0;
    c.rDiv   = 4'd1;
    c.vcoAdj = 2'd3;
    c.paBias = 3'd7;
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] packWord(cfg_t c, logic [1:0] idx,
                                                 logic [CORR_W-1:0] corrVal);
    logic [WORD_W-1:0] w;
    case (idx)
      2'd0: w = {5'b0, c.outDiv, c.vcoAdj, c.clkOutDiv, c.oscOff, c.xtalDbl,
                 c.rDiv, corrVal, 2'd0};
      2'd1: w = {9'b0, c.presc, c.intN, c.fracN, 2'd1};
      2'd2: w = {7'b0, c.indexCnt, c.shapeCtl, c.deviation, c.paLevel,
                 c.shapedOok, c.modSel, 2'd2};
      default: w = {c.modTest, c.pllTest, c.paBias, c.vcoBias, c.ldPrec,
                    c.muxSel, c.vcoOff, c.bleedDn, c.bleedUp, c.cpCur,
                    c.dataInv, c.clkOutEn, c.paEn, c.pllEn, 2'd3};
    endcase
    return w;
  endfunction

endpackage

// File: rtl/synth_cfg_dp.sv
module synth_cfg_dp
  import synth_cfg_pkg::*;
#(
  parameter int WAIT_W   = 8,
  parameter int TONE_W   = 8,
  parameter int WAIT_DEF = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  cfg_t              cfgIn,
  input  logic [WAIT_W-1:0] waitIn,
  input  logic [TONE_W-1:0] toneIn,
  input  logic              busy,
  output logic              msb,
  output logic [WAIT_W-1:0] waitOut
);

  cfg_t              cfgQ;
  logic [WAIT_W-1:0] waitQ;
  logic [TONE_W-1:0] toneQ;
  logic [WORD_W-1:0] shiftQ;

  logic [TONE_W-1:0] toneSrc;
  logic [CORR_W-1:0] corrSum;
  logic [WORD_W-1:0] wordNext;

  always_comb begin
    toneSrc  = strb.capTone ? toneIn : toneQ;
    corrSum  = CORR_W'(cfgQ.corr + CORR_W'(toneSrc));
    wordNext = strb.tone ? packWord(cfgQ, 2'd0, corrSum)
                         : packWord(cfgQ, strb.sel, cfgQ.corr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgQ   <= defaultCfg();
      waitQ  <= WAIT_W'(WAIT_DEF);
      toneQ  <= '0;
      shiftQ <= '0;
    end else begin
      if (strb.cfgTake) begin
        cfgQ  <= cfgIn;
        waitQ <= waitIn;
      end
      if (strb.capTone) toneQ <= toneIn;
      if (strb.load)       shiftQ <= wordNext;
      else if (strb.shift) shiftQ <= {shiftQ[WORD_W-2:0], 1'b0};
    end
  end

  assign msb     = shiftQ[WORD_W-1];
  assign waitOut = waitQ;

  AST_CORR_HELD: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cfgQ.corr)); // R8

endmodule

// File: rtl/synth_cfg_ctrl.sv
module synth_cfg_ctrl
  import synth_cfg_pkg::*;
#(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startFull,
  input  logic              startTone,
  input  logic              cfgWe,
  input  logic [WAIT_W-1:0] waitIn,
  input  logic              msb,
  output strobe_t           strb,
  output logic              busy,
  output logic              le,
  output logic              sclk,
  output logic              sdata
);

  localparam int CNT_W = WAIT_W + 1;
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_LEAD, S_SETUP, S_BLO, S_BHI, S_LATCH, S_DROP, S_END
  } state_t;

  state_t            st, nxt;
  logic [CNT_W-1:0]  cnt, cntN;
  logic [BIT_W-1:0]  bitIdx, bitN;
  logic [1:0]        wordIdx, wordN;
  logic              toneMode, toneModeN;
  logic              pend, pendN;

  logic [WAIT_W-1:0] waitEff;
  logic [CNT_W-1:0]  twoWm1, oneWm1;

  always_comb begin
    waitEff = (waitIn == '0) ? WAIT_W'(1) : waitIn;
    twoWm1  = {waitEff, 1'b0} - CNT_W'(1);
    oneWm1  = {1'b0, waitEff} - CNT_W'(1);
  end

  always_comb begin
    nxt       = st;
    cntN      = cnt;
    bitN      = bitIdx;
    wordN     = wordIdx;
    toneModeN = toneMode;
    pendN     = pend;
    strb      = '0;

    // queue a tone while a full update runs
    if (st != S_IDLE && !toneMode && !pend && startTone) begin
      strb.capTone = 1'b1;
      pendN        = 1'b1;
    end

    case (st)
      S_IDLE: begin
        if (startFull) begin
          toneModeN = 1'b0;
          wordN     = 2'd0;
          strb.load = 1'b1;
          strb.sel  = 2'd0;
          nxt       = S_LEAD;
          cntN      = twoWm1;
          if (startTone) begin
            strb.capTone = 1'b1;
            pendN        = 1'b1;
          end
        end else if (startTone) begin
          toneModeN    = 1'b1;
          strb.capTone = 1'b1;
          strb.load    = 1'b1;
          strb.tone    = 1'b1;
          nxt          = S_LEAD;
          cntN         = twoWm1;
        end else if (cfgWe) begin
          strb.cfgTake = 1'b1;
        end
      end
      S_LEAD: begin
        if (cnt == '0) begin
          nxt  = S_SETUP;
          cntN = oneWm1;
        end else cntN = cnt - CNT_W'(1);
      end
      S_SETUP: begin
        if (cnt == '0) begin
          nxt  = S_BLO;
          cntN = twoWm1;
          bitN = '0;
        end else cntN = cnt - CNT_W'(1);
      end
      S_BLO: begin
        if (cnt == '0) begin
          if (bitIdx == LAST_BIT) begin
            nxt  = S_LATCH;
            cntN = twoWm1;
          end else nxt = S_BHI;
        end else cntN = cnt - CNT_W'(1);
      end
      S_BHI: begin
        strb.shift = 1'b1;
        bitN       = bitIdx + BIT_W'(1);
        nxt        = S_BLO;
        cntN       = twoWm1;
      end
      S_LATCH: begin
        if (cnt == '0) nxt = S_DROP;
        else cntN = cnt - CNT_W'(1);
      end
      S_DROP: nxt = S_END;
      S_END: begin
        if (!toneMode && wordIdx != 2'd3) begin
          wordN     = wordIdx + 2'd1;
          strb.load = 1'b1;
          strb.sel  = wordIdx + 2'd1;
          nxt       = S_LEAD;
          cntN      = twoWm1;
        end else if (!toneMode && (pend || startTone)) begin
          pendN     = 1'b0;
          toneModeN = 1'b1;
          strb.load = 1'b1;
          strb.tone = 1'b1;
          nxt       = S_LEAD;
          cntN      = twoWm1;
        end else begin
          pendN = 1'b0;
          nxt   = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bitIdx   <= '0;
      wordIdx  <= '0;
      toneMode <= 1'b0;
      pend     <= 1'b0;
      le       <= 1'b0;
      sclk     <= 1'b1;
    end else begin
      st       <= nxt;
      cnt      <= cntN;
      bitIdx   <= bitN;
      wordIdx  <= wordN;
      toneMode <= toneModeN;
      pend     <= pendN;
      le       <= (nxt inside {S_LEAD, S_LATCH, S_DROP});
      sclk     <= (nxt inside {S_IDLE, S_END, S_LEAD, S_BHI, S_LATCH});
    end
  end

  always_comb begin
    busy = (st != S_IDLE);
    case (st)
      S_IDLE, S_END, S_LEAD: sdata = 1'b1;
      S_SETUP:               sdata = 1'b0;
      default:               sdata = msb;
    endcase
  end

  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!le && sclk && sdata)); // R9

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (!busy && (startFull || startTone)) |=> (busy && le)); // R9

  AST_LE_RISE_CLK_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(le) |-> sclk); // R7

  AST_PEND_IN_FULL: assert property (@(posedge clk) disable iff (rst)
    pend |-> !toneMode); // R11

endmodule

// File: rtl/synth_cfg_writer.sv
module synth_cfg_writer
  import synth_cfg_pkg::*;
#(
  parameter int WAIT_W = 8,
  parameter int TONE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [10:0]       corr,
  input  logic [3:0]        rDiv,
  input  logic              xtalDbl,
  input  logic              oscOff,
  input  logic [3:0]        clkOutDiv,
  input  logic [1:0]        vcoAdj,
  input  logic [1:0]        outDiv,
  input  logic [11:0]       fracN,
  input  logic [7:0]        intN,
  input  logic              presc,
  input  logic [1:0]        modSel,
  input  logic              shapedOok,
  input  logic [5:0]        paLevel,
  input  logic [8:0]        deviation,
  input  logic [2:0]        shapeCtl,
  input  logic [1:0]        indexCnt,
  input  logic              pllEn,
  input  logic              paEn,
  input  logic              clkOutEn,
  input  logic              dataInv,
  input  logic [1:0]        cpCur,
  input  logic              bleedUp,
  input  logic              bleedDn,
  input  logic              vcoOff,
  input  logic [3:0]        muxSel,
  input  logic              ldPrec,
  input  logic [3:0]        vcoBias,
  input  logic [2:0]        paBias,
  input  logic [4:0]        pllTest,
  input  logic [3:0]        modTest,
  input  logic [WAIT_W-1:0] waitIn,
  input  logic              cfgWe,
  input  logic              startFull,
  input  logic              startTone,
  input  logic [TONE_W-1:0] toneOfs,
  output logic              le,
  output logic              sclk,
  output logic              sdata,
  output logic              busy
);

  cfg_t              cfgIn;
  strobe_t           strb;
  logic              msb;
  logic [WAIT_W-1:0] waitCur;

  always_comb begin
    cfgIn.corr      = corr;
    cfgIn.rDiv      = rDiv;
    cfgIn.xtalDbl   = xtalDbl;
    cfgIn.oscOff    = oscOff;
    cfgIn.clkOutDiv = clkOutDiv;
    cfgIn.vcoAdj    = vcoAdj;
    cfgIn.outDiv    = outDiv;
    cfgIn.fracN     = fracN;
    cfgIn.intN      = intN;
    cfgIn.presc     = presc;
    cfgIn.modSel    = modSel;
    cfgIn.shapedOok = shapedOok;
    cfgIn.paLevel   = paLevel;
    cfgIn.deviation = deviation;
    cfgIn.shapeCtl  = shapeCtl;
    cfgIn.indexCnt  = indexCnt;
    cfgIn.pllEn     = pllEn;
    cfgIn.paEn      = paEn;
    cfgIn.clkOutEn  = clkOutEn;
    cfgIn.dataInv   = dataInv;
    cfgIn.cpCur     = cpCur;
    cfgIn.bleedUp   = bleedUp;
    cfgIn.bleedDn   = bleedDn;
    cfgIn.vcoOff    = vcoOff;
    cfgIn.muxSel    = muxSel;
    cfgIn.ldPrec    = ldPrec;
    cfgIn.vcoBias   = vcoBias;
    cfgIn.paBias    = paBias;
    cfgIn.pllTest   = pllTest;
    cfgIn.modTest   = modTest;
  end

  synth_cfg_ctrl #(.WAIT_W(WAIT_W)) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .startFull (startFull),
    .startTone (startTone),
    .cfgWe     (cfgWe),
    .waitIn    (waitCur),
    .msb       (msb),
    .strb      (strb),
    .busy      (busy),
    .le        (le),
    .sclk      (sclk),
    .sdata     (sdata)
  );

  synth_cfg_dp #(.WAIT_W(WAIT_W), .TONE_W(TONE_W)) uDp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .cfgIn   (cfgIn),
    .waitIn  (waitIn),
    .toneIn  (toneOfs),
    .busy    (busy),
    .msb     (msb),
    .waitOut (waitCur)
  );

endmodule

// File: tb/sim_synth_cfg_writer.sv
module sim_synth_cfg_writer;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst;
  logic [10:0] corr; logic [3:0] rDiv; logic xtalDbl, oscOff;
  logic [3:0] clkOutDiv; logic [1:0] vcoAdj, outDiv;
  logic [11:0] fracN; logic [7:0] intN; logic presc;
  logic [1:0] modSel; logic shapedOok; logic [5:0] paLevel;
  logic [8:0] deviation; logic [2:0] shapeCtl; logic [1:0] indexCnt;
  logic pllEn, paEn, clkOutEn, dataInv; logic [1:0] cpCur;
  logic bleedUp, bleedDn, vcoOff; logic [3:0] muxSel; logic ldPrec;
  logic [3:0] vcoBias; logic [2:0] paBias; logic [4:0] pllTest; logic [3:0] modTest;
  logic [7:0] waitIn; logic cfgWe, startFull, startTone; logic [7:0] toneOfs;
  logic le, sclk, sdata, busy;

  synth_cfg_writer u0 (.*);

  int errors = 0;
  int checks = 0;
  int expW = 5;
  bit done = 0;
  logic [31:0] expQ[$];
  string tagQ[$];

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // expected words, from the field layouts
  function automatic logic [31:0] expW0(logic [10:0] c);
    return {5'b0, outDiv, vcoAdj, clkOutDiv, oscOff, xtalDbl, rDiv, c, 2'd0};
  endfunction
  function automatic logic [31:0] expW1();
    return {9'b0, presc, intN, fracN, 2'd1};
  endfunction
  function automatic logic [31:0] expW2();
    return {7'b0, indexCnt, shapeCtl, deviation, paLevel, shapedOok, modSel, 2'd2};
  endfunction
  function automatic logic [31:0] expW3();
    return {modTest, pllTest, paBias, vcoBias, ldPrec, muxSel, vcoOff, bleedDn,
            bleedUp, cpCur, dataInv, clkOutEn, paEn, pllEn, 2'd3};
  endfunction

  task automatic pushFull(string t0, string t1, string t2, string t3);
    expQ.push_back(expW0(corr)); tagQ.push_back(t0);
    expQ.push_back(expW1());     tagQ.push_back(t1);
    expQ.push_back(expW2());     tagQ.push_back(t2);
    expQ.push_back(expW3());     tagQ.push_back(t3);
  endtask

  task automatic pushTone(logic [10:0] storedCorr, logic [7:0] t, string tag);
    logic [10:0] s;
    s = storedCorr + {3'b0, t};
    expQ.push_back(expW0(s)); tagQ.push_back(tag);
  endtask

  // monitor: rebuild words from the pins, check framing, compare
  logic prevLe, prevSclk;
  int bitCnt, leadRun, lowRun, latchHi, dropRun, lastLead;
  bit badBit;
  logic [31:0] acc;

  always @(negedge clk) begin
    if (rst) begin
      prevLe = 1'b0; prevSclk = 1'b1; bitCnt = 0; leadRun = 0;
      lowRun = 0; latchHi = 0; dropRun = 0; badBit = 0; acc = '0;
    end else begin
      if (sclk && !prevSclk && !prevLe) begin
        acc = {acc[30:0], sdata};
        if (bitCnt == 0) chk(lowRun == 3*expW, "R5", lowRun, 3*expW);
        else if (lowRun != 2*expW) badBit = 1;
        bitCnt++;
      end
      if (!sclk && !le) lowRun++;
      else if (sclk) lowRun = 0;
      if (le && bitCnt == 0) leadRun++;
      if (le && sclk && bitCnt == 32) latchHi++;
      if (le && !sclk && bitCnt == 32) dropRun++;
      if (!le && prevLe) begin
        if (bitCnt == 0) begin
          chk(leadRun == 2*expW, "R5", leadRun, 2*expW);
          lastLead = leadRun;
          leadRun = 0;
        end else begin
          chk(bitCnt == 32 && !badBit, "R6", bitCnt, 32);
          chk(latchHi == 2*expW && dropRun == 1 && !prevSclk, "R7",
              latchHi, 2*expW);
          if (expQ.size() == 0) begin
            chk(0, "R10", acc, 32'hx);
          end else begin
            logic [31:0] e; string t;
            e = expQ.pop_front(); t = tagQ.pop_front();
            chk(acc[1:0] == e[1:0], "R1", acc[1:0], e[1:0]);
            chk(acc == e, t, acc, e);
          end
          bitCnt = 0; latchHi = 0; dropRun = 0; badBit = 0; acc = '0;
        end
      end
      prevLe = le; prevSclk = sclk;
    end
  end

  task automatic doCfg();
    @(negedge clk) cfgWe = 1;
    @(negedge clk) cfgWe = 0;
  endtask

  task automatic startReq(bit f, bit t);
    @(negedge clk) begin startFull = f; startTone = t; end
    @(negedge clk) begin startFull = 0; startTone = 0; end
    chk(busy === 1'b1 && le === 1'b1, "R9", {busy, le}, 2'b11);
  endtask

  task automatic pulseTone(logic [7:0] t);
    @(negedge clk) begin startTone = 1; toneOfs = t; end
    @(negedge clk) startTone = 0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    {corr, rDiv, xtalDbl, oscOff, clkOutDiv, vcoAdj, outDiv, fracN, intN, presc,
     modSel, shapedOok, paLevel, deviation, shapeCtl, indexCnt, pllEn, paEn,
     clkOutEn, dataInv, cpCur, bleedUp, bleedDn, vcoOff, muxSel, ldPrec,
     vcoBias, paBias, pllTest, modTest} = '0;
    waitIn = 8'd5; cfgWe = 0; startFull = 0; startTone = 0; toneOfs = 0;
    rst = 1;
    repeat (4) @(negedge clk);
    chk(le === 1'b0 && sclk === 1'b1 && sdata === 1'b1 && busy === 1'b0,
        "R12", {le, sclk, sdata, busy}, 4'b0110);
    rst = 0;
    @(negedge clk);
    chk(le === 1'b0 && sclk === 1'b1 && sdata === 1'b1, "R9",
        {le, sclk, sdata}, 3'b011);

    // reset defaults: model fields match the reset values, no capture
    rDiv = 4'd1; vcoAdj = 2'd3; paBias = 3'd7; expW = 5;
    pushFull("R12", "R12", "R12", "R12");
    startReq(1, 0);
    waitIdle();
    chk(expQ.size() == 0, "R12", expQ.size(), 0);

    // distinct field pattern, W = 2
    corr = 11'h5A3; rDiv = 4'hC; xtalDbl = 1; oscOff = 0; clkOutDiv = 4'h9;
    vcoAdj = 2'd2; outDiv = 2'd1; fracN = 12'hABC; intN = 8'h96; presc = 1;
    modSel = 2'd2; shapedOok = 1; paLevel = 6'h2D; deviation = 9'h1B7;
    shapeCtl = 3'd5; indexCnt = 2'd2; pllEn = 1; paEn = 0; clkOutEn = 1;
    dataInv = 0; cpCur = 2'd1; bleedUp = 1; bleedDn = 0; vcoOff = 1;
    muxSel = 4'hA; ldPrec = 1; vcoBias = 4'h6; paBias = 3'd3;
    pllTest = 5'h15; modTest = 4'h9; waitIn = 8'd2;
    doCfg(); expW = 2;
    pushFull("R2", "R3", "R3", "R4");
    startReq(1, 0);
    repeat (30) @(negedge clk);
    // R10: requests and configuration writes while busy are dropped
    @(negedge clk) startFull = 1;
    @(negedge clk) startFull = 0;
    corr = 11'h111;
    doCfg();
    corr = 11'h5A3;
    waitIdle();
    chk(expQ.size() == 0, "R10", expQ.size(), 0);
    pushFull("R10", "R10", "R10", "R10");
    startReq(1, 0);
    waitIdle();
    chk(expQ.size() == 0, "R10", expQ.size(), 0);

    // tone with wrap of the correction sum
    corr = 11'h7F0;
    doCfg();
    toneOfs = 8'h35;
    pushTone(11'h7F0, 8'h35, "R8");
    startReq(0, 1);
    repeat (20) @(negedge clk);
    pulseTone(8'h11);   // ignored during a tone transfer
    waitIdle();
    chk(expQ.size() == 0, "R10", expQ.size(), 0);
    pushFull("R8", "R3", "R3", "R4");
    startReq(1, 0);
    waitIdle();
    chk(expQ.size() == 0, "R8", expQ.size(), 0);

    // tone queued during a full update; second tone dropped
    pushFull("R11", "R11", "R11", "R11");
    startReq(1, 0);
    repeat (40) @(negedge clk);
    pulseTone(8'h03);
    pushTone(11'h7F0, 8'h03, "R11");
    repeat (40) @(negedge clk);
    pulseTone(8'h77);
    waitIdle();
    chk(expQ.size() == 0, "R11", expQ.size(), 0);

    // full and tone requested in the same idle cycle
    corr = 11'h0C4;
    doCfg();
    toneOfs = 8'h10;
    pushFull("R11", "R11", "R11", "R11");
    pushTone(11'h0C4, 8'h10, "R11");
    startReq(1, 1);
    waitIdle();
    chk(expQ.size() == 0, "R11", expQ.size(), 0);

    // zero wait count acts as one
    waitIn = 8'd0;
    doCfg(); expW = 1;
    pushFull("R13", "R13", "R13", "R13");
    startReq(1, 0);
    waitIdle();
    chk(lastLead == 2, "R13", lastLead, 2);
    chk(expQ.size() == 0, "R13", expQ.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R9 act=%h exp=%h", busy, 1'b0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule